// File: doc/BRIEF.md
# Host-to-core shared memory bridge

The bridge takes single-byte accesses from a host bus front end and turns each one into at most one transaction on an internal core memory bus. Three access kinds arrive: plain memory, firmware-hub memory and indirect accesses made through I/O cycles. Memory and firmware-hub addresses are first decoded against two zones: a fixed legacy BIOS zone and a user-defined window of 2^n bytes. The address is then translated into the internal shared-memory address space. Indirect accesses already carry an internal address and skip zone decode.

Every translated access is checked before it is forwarded. The target must fall in the core's base memory or expansion memory range. That range must not be protected for the access direction. A write must also have the host lock granted. Writes to the on-chip flash, which is the base range, can be marked as page-erase writes.

While a memory or firmware-hub transaction is outstanding on the core bus, the host status reports long-wait. A rejected access finishes at once without touching the core bus, returns 0xFF and sets a sticky violation flag.

Top module: `shm_bridge`

## Requirements
- R1: After reset, core_valid_o, host_done_o and viol_o are 0 and host_sync_o is IDLE (2'b00).
- R2: With legacy_en_i set, a memory or firmware-hub address hits the legacy zone when bits [31:17] are all ones, or when bits [31:20] are zero and bits [19:17] are all ones. The translated core address is seventeen-bit host offset [16:0] below fifteen one-bits.
- R3: With user_en_i set and win_exp_i = n in 12..24, an address hits the user window when its bits [31:n] equal user_base_i[31:n]. The translated address keeps host bits [n-1:0] and forces bits [31:n] to one. When both zones hit, the legacy translation is used.
- R4: An access is ignored when its zone is disabled, when n is outside 12..24, or when no zone hits. An ignored access produces no core transaction and no host_done_o, and host_sync_o stays IDLE.
- R5: Kind encoding is 2'b00 memory, 2'b01 firmware-hub and 2'b10 indirect. An indirect access skips zone decode and its host address is used unchanged as the core address.
- R6: An access is forwarded only if the core address is in [BASE_LO, BASE_HI] (base range) or [EXP_LO, EXP_HI] (expansion range). The read or write protection input of that range must also be clear for the access direction.
- R7: A write is forwarded only when host_lock_i is 1.
- R8: A rejected access issues no core transaction. host_done_o pulses in the cycle after the request with host_rdata_o = 0xFF, and viol_o becomes 1 and stays 1 until reset.
- R9: Once core_valid_o rises, it stays high with stable address, data, write and erase until core_ready_i. Read data is captured on the acknowledge edge, and host_done_o pulses for one cycle right after it carrying that data.
- R10: host_sync_o is LWAIT (2'b01) while a memory or firmware-hub transaction is outstanding and READY (2'b10) in the host_done_o cycle. An indirect access never shows LWAIT.
- R11: core_erase_o is 1 on a forwarded write when erase_en_i and flash_en_i are both set and the core address is in the base range; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | One-cycle host request strobe |
| req_kind_i | input | 2 | Access kind: 0 memory, 1 firmware-hub, 2 indirect |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | 32 | Host address (internal address for indirect) |
| req_wdata_i | input | 8 | Write byte |
| legacy_en_i | input | 1 | Legacy BIOS zone enable |
| user_en_i | input | 1 | User window enable |
| user_base_i | input | 32 | User window base |
| win_exp_i | input | 5 | User window size exponent n |
| base_rd_prot_i | input | 1 | Read protect, base range |
| base_wr_prot_i | input | 1 | Write protect, base range |
| exp_rd_prot_i | input | 1 | Read protect, expansion range |
| exp_wr_prot_i | input | 1 | Write protect, expansion range |
| host_lock_i | input | 1 | Host write lock granted |
| erase_en_i | input | 1 | Erase control |
| flash_en_i | input | 1 | On-chip flash enabled |
| host_sync_o | output | 2 | Host status: 0 idle, 1 long-wait, 2 ready |
| host_done_o | output | 1 | Access completion pulse |
| host_rdata_o | output | 8 | Read result |
| viol_o | output | 1 | Sticky access violation |
| core_valid_o | output | 1 | Core bus request |
| core_ready_i | input | 1 | Core bus acknowledge |
| core_addr_o | output | 32 | Core bus address |
| core_wdata_o | output | 8 | Core bus write data |
| core_write_o | output | 1 | Core bus write flag |
| core_erase_o | output | 1 | Page-erase qualifier |
| core_rdata_i | input | 8 | Core bus read data |

## Verification
The assertions assume that the host raises req_valid_i only while the bridge is idle, that is, not between a request and its host_done_o. They also assume that the configuration and protection inputs do not change during an access. The bench issues each request only after the previous one has completed or has been shown to be ignored, and it changes configuration only between accesses. The core responder acknowledges after a chosen delay and never without a pending request.

// File: rtl/shm_pkg.sv
package shm_pkg;
  typedef enum logic [1:0] {
    KIND_MEM = 2'b00,
    KIND_FWH = 2'b01,
    KIND_IND = 2'b10
  } kind_e;

  typedef enum logic [1:0] {
    SYNC_IDLE  = 2'b00,
    SYNC_LWAIT = 2'b01,
    SYNC_READY = 2'b10
  } sync_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUSY,
    ST_DONE
  } state_e;
endpackage

// File: rtl/shm_zone_xlate.sv
module shm_zone_xlate
  import shm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEG_KEEP = 17,
  parameter int LEG_LOW  = 20,
  parameter int WIN_MIN  = 12,
  parameter int WIN_MAX  = 24,
  parameter int EXP_W    = 5
) (
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              legacy_en_i,
  input  logic              user_en_i,
  input  logic [ADDR_W-1:0] user_base_i,
  input  logic [EXP_W-1:0]  win_exp_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] xaddr_o
);
  localparam int LEG_HI_W = ADDR_W - LEG_KEEP;

  logic leg_top, leg_alias, leg_hit;
  logic win_ok, usr_hit, is_ind;
  logic [ADDR_W-1:0] win_mask;

  assign is_ind    = (kind_i == KIND_IND);
  assign leg_top   = &addr_i[ADDR_W-1:LEG_KEEP];
  assign leg_alias = (addr_i[ADDR_W-1:LEG_LOW] == '0) && (&addr_i[LEG_LOW-1:LEG_KEEP]);
  assign leg_hit   = legacy_en_i && (leg_top || leg_alias);

  assign win_ok   = user_en_i && (int'(win_exp_i) >= WIN_MIN) && (int'(win_exp_i) <= WIN_MAX);
  assign win_mask = {ADDR_W{1'b1}} << win_exp_i;
  assign usr_hit  = win_ok && (((addr_i ^ user_base_i) & win_mask) == '0);

  always_comb begin
    hit_o   = 1'b0;
    xaddr_o = addr_i;
    if (is_ind) begin
      hit_o = 1'b1;
    end else if (leg_hit) begin
      hit_o   = 1'b1;
      xaddr_o = {{LEG_HI_W{1'b1}}, addr_i[LEG_KEEP-1:0]};
    end else if (usr_hit) begin
      hit_o   = 1'b1;
      xaddr_o = addr_i | win_mask;
    end
  end
endmodule

// File: rtl/shm_guard.sv
module shm_guard #(
  parameter int          ADDR_W  = 32,
  parameter logic [31:0] BASE_LO = 32'hFFF0_0000,
  parameter logic [31:0] BASE_HI = 32'hFFFF_FFFF,
  parameter logic [31:0] EXP_LO  = 32'hFF00_0000,
  parameter logic [31:0] EXP_HI  = 32'hFF7F_FFFF
) (
  input  logic [ADDR_W-1:0] xaddr_i,
  input  logic              write_i,
  input  logic              base_rd_prot_i,
  input  logic              base_wr_prot_i,
  input  logic              exp_rd_prot_i,
  input  logic              exp_wr_prot_i,
  input  logic              host_lock_i,
  input  logic              erase_en_i,
  input  logic              flash_en_i,
  output logic              permit_o,
  output logic              erase_o
);
  logic in_base, in_exp, prot, lock_ok;

  assign in_base = (xaddr_i >= BASE_LO[ADDR_W-1:0]) && (xaddr_i <= BASE_HI[ADDR_W-1:0]);
  assign in_exp  = (xaddr_i >= EXP_LO[ADDR_W-1:0]) && (xaddr_i <= EXP_HI[ADDR_W-1:0]);

  always_comb begin
    prot = 1'b1;
    if (in_base)     prot = write_i ? base_wr_prot_i : base_rd_prot_i;
    else if (in_exp) prot = write_i ? exp_wr_prot_i : exp_rd_prot_i;
  end

  assign lock_ok  = !write_i || host_lock_i;
  assign permit_o = (in_base || in_exp) && !prot && lock_ok;
  assign erase_o  = write_i && erase_en_i && flash_en_i && in_base;
endmodule

// File: rtl/shm_core_seq.sv
module shm_core_seq
  import shm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              hit_i,
  input  logic              permit_i,
  input  logic [1:0]        kind_i,
  input  logic              write_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] xaddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [1:0]        host_sync_o,
  output logic              host_done_o,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              viol_o,
  output logic              core_valid_o,
  input  logic              core_ready_i,
  output logic [ADDR_W-1:0] core_addr_o,
  output logic [DATA_W-1:0] core_wdata_o,
  output logic              core_write_o,
  output logic              core_erase_o,
  input  logic [DATA_W-1:0] core_rdata_i
);
  state_e            state_q;
  logic [1:0]        kind_q;
  logic              write_q, erase_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_MEM;
      write_q <= 1'b0;
      erase_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      viol_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i && hit_i) begin
            kind_q  <= kind_i;
            write_q <= write_i;
            if (permit_i) begin
              state_q <= ST_BUSY;
              erase_q <= erase_i;
              addr_q  <= xaddr_i;
              wdata_q <= wdata_i;
            end else begin
              // rejected: finish locally
              state_q <= ST_DONE;
              rdata_q <= '1;
              viol_q  <= 1'b1;
            end
          end
        end
        ST_BUSY: begin
          if (core_ready_i) begin
            state_q <= ST_DONE;
            rdata_q <= write_q ? '1 : core_rdata_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign core_valid_o = (state_q == ST_BUSY);
  assign core_addr_o  = addr_q;
  assign core_wdata_o = wdata_q;
  assign core_write_o = write_q;
  assign core_erase_o = core_valid_o && erase_q;
  assign host_done_o  = (state_q == ST_DONE);
  assign host_rdata_o = rdata_q;
  assign viol_o       = viol_q;

  always_comb begin
    host_sync_o = SYNC_IDLE;
    if (state_q == ST_DONE) host_sync_o = SYNC_READY;
    else if (state_q == ST_BUSY && kind_q != KIND_IND) host_sync_o = SYNC_LWAIT;
  end

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_valid_o && !core_ready_i |=> core_valid_o && $stable(core_addr_o)
      && $stable(core_write_o) && $stable(core_wdata_o) && $stable(core_erase_o));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_done_o |=> !host_done_o);
  // R8
  reject_no_txn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(viol_o) |-> !core_valid_o && host_done_o);
  // R8
  viol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o);
  // R10
  no_ready_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_valid_o |-> host_sync_o != SYNC_READY);
endmodule

// File: rtl/shm_bridge.sv
module shm_bridge
  import shm_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 8,
  parameter int          EXP_W    = 5,
  parameter int          LEG_KEEP = 17,
  parameter int          LEG_LOW  = 20,
  parameter int          WIN_MIN  = 12,
  parameter int          WIN_MAX  = 24,
  parameter logic [31:0] BASE_LO  = 32'hFFF0_0000,
  parameter logic [31:0] BASE_HI  = 32'hFFFF_FFFF,
  parameter logic [31:0] EXP_LO   = 32'hFF00_0000,
  parameter logic [31:0] EXP_HI   = 32'hFF7F_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              legacy_en_i,
  input  logic              user_en_i,
  input  logic [ADDR_W-1:0] user_base_i,
  input  logic [EXP_W-1:0]  win_exp_i,
  input  logic              base_rd_prot_i,
  input  logic              base_wr_prot_i,
  input  logic              exp_rd_prot_i,
  input  logic              exp_wr_prot_i,
  input  logic              host_lock_i,
  input  logic              erase_en_i,
  input  logic              flash_en_i,
  output logic [1:0]        host_sync_o,
  output logic              host_done_o,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              viol_o,
  output logic              core_valid_o,
  input  logic              core_ready_i,
  output logic [ADDR_W-1:0] core_addr_o,
  output logic [DATA_W-1:0] core_wdata_o,
  output logic              core_write_o,
  output logic              core_erase_o,
  input  logic [DATA_W-1:0] core_rdata_i
);
  logic              hit, permit, erase;
  logic [ADDR_W-1:0] xaddr;

  shm_zone_xlate #(
    .ADDR_W(ADDR_W), .LEG_KEEP(LEG_KEEP), .LEG_LOW(LEG_LOW),
    .WIN_MIN(WIN_MIN), .WIN_MAX(WIN_MAX), .EXP_W(EXP_W)
  ) u_xlate (
    .kind_i(req_kind_i), .addr_i(req_addr_i), .legacy_en_i(legacy_en_i),
    .user_en_i(user_en_i), .user_base_i(user_base_i), .win_exp_i(win_exp_i),
    .hit_o(hit), .xaddr_o(xaddr)
  );

  shm_guard #(
    .ADDR_W(ADDR_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI),
    .EXP_LO(EXP_LO), .EXP_HI(EXP_HI)
  ) u_guard (
    .xaddr_i(xaddr), .write_i(req_write_i),
    .base_rd_prot_i(base_rd_prot_i), .base_wr_prot_i(base_wr_prot_i),
    .exp_rd_prot_i(exp_rd_prot_i), .exp_wr_prot_i(exp_wr_prot_i),
    .host_lock_i(host_lock_i), .erase_en_i(erase_en_i), .flash_en_i(flash_en_i),
    .permit_o(permit), .erase_o(erase)
  );

  shm_core_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(req_valid_i), .hit_i(hit),
    .permit_i(permit), .kind_i(req_kind_i), .write_i(req_write_i),
    .erase_i(erase), .xaddr_i(xaddr), .wdata_i(req_wdata_i),
    .host_sync_o(host_sync_o), .host_done_o(host_done_o),
    .host_rdata_o(host_rdata_o), .viol_o(viol_o),
    .core_valid_o(core_valid_o), .core_ready_i(core_ready_i),
    .core_addr_o(core_addr_o), .core_wdata_o(core_wdata_o),
    .core_write_o(core_write_o), .core_erase_o(core_erase_o),
    .core_rdata_i(core_rdata_i)
  );

  // R7
  write_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_valid_o) && core_write_o |-> $past(host_lock_i));
  // R11
  erase_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_erase_o |-> core_write_o && core_valid_o && core_addr_o >= BASE_LO[ADDR_W-1:0]);
  // R2
  legacy_xlate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_valid_o) && $past(legacy_en_i) && $past(req_kind_i) != KIND_IND
      && (&$past(req_addr_i[ADDR_W-1:LEG_KEEP]))
      |-> core_addr_o == $past(req_addr_i));
endmodule

// File: tb/tb_shm_bridge.sv
module tb_shm_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [31:0] req_addr = '0, user_base = '0;
  logic [7:0]  req_wdata = '0;
  logic        legacy_en = 1'b0, user_en = 1'b0;
  logic [4:0]  win_exp = 5'd12;
  logic        brp = 1'b0, bwp = 1'b0, erp = 1'b0, ewp = 1'b0;
  logic        lock = 1'b0, erase_en = 1'b0, flash_en = 1'b0;
  logic [1:0]  sync;
  logic        done, viol, cvalid, cwrite, cerase;
  logic        cready = 1'b0;
  logic [7:0]  rdata, cwdata;
  logic [7:0]  crdata = '0;
  logic [31:0] caddr;

  int tests = 0, fails = 0;
  int core_cnt = 0, done_cnt = 0;
  int resp_delay = 0;
  logic [1:0] cur_kind = 2'b00;
  bit finished = 0;

  typedef struct { logic [31:0] a; logic w; logic e; logic [7:0] d; string tag; } core_exp_t;
  typedef struct { logic rd; logic [7:0] rdata; logic viol; string tag; } host_exp_t;
  core_exp_t core_q[$];
  host_exp_t host_q[$];

  always #2 clk = ~clk;

  shm_bridge dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .legacy_en_i(legacy_en), .user_en_i(user_en), .user_base_i(user_base),
    .win_exp_i(win_exp), .base_rd_prot_i(brp), .base_wr_prot_i(bwp),
    .exp_rd_prot_i(erp), .exp_wr_prot_i(ewp), .host_lock_i(lock),
    .erase_en_i(erase_en), .flash_en_i(flash_en), .host_sync_o(sync),
    .host_done_o(done), .host_rdata_o(rdata), .viol_o(viol),
    .core_valid_o(cvalid), .core_ready_i(cready), .core_addr_o(caddr),
    .core_wdata_o(cwdata), .core_write_o(cwrite), .core_erase_o(cerase),
    .core_rdata_i(crdata)
  );

  function automatic logic [7:0] resp_data(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // core responder: acknowledges after resp_delay cycles
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk);
      #1;
      if (cvalid && !cready) begin
        if (cnt >= resp_delay) begin
          cready = 1'b1;
          crdata = resp_data(caddr);
          cnt = 0;
        end else cnt++;
      end else cready = 1'b0;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (cvalid) begin
        logic [1:0] es;
        es = (cur_kind == 2'b10) ? 2'b00 : 2'b01;
        check(sync == es, "R10 sync while busy", sync, es);
      end
      if (cvalid && cready) begin
        core_cnt++;
        if (core_q.size() == 0) check(0, "R4 unexpected core txn", caddr, 0);
        else begin
          core_exp_t c;
          c = core_q.pop_front();
          check(caddr == c.a, {c.tag, " core addr"}, caddr, c.a);
          check(cwrite == c.w, {c.tag, " core write"}, cwrite, c.w);
          check(cerase == c.e, {c.tag, " R11 erase"}, cerase, c.e);
          if (c.w) check(cwdata == c.d, {c.tag, " core wdata"}, cwdata, c.d);
        end
      end
      if (done) begin
        done_cnt++;
        check(sync == 2'b10, "R10 ready on done", sync, 2'b10);
        if (host_q.size() == 0) check(0, "R4 unexpected done", done, 0);
        else begin
          host_exp_t h;
          h = host_q.pop_front();
          if (h.rd) check(rdata == h.rdata, {h.tag, " rdata"}, rdata, h.rdata);
          check(viol == h.viol, {h.tag, " viol"}, viol, h.viol);
        end
      end
    end
  end

  // fwd: forwarded; ign: ignored (no completion)
  task automatic access(input logic [1:0] kind, input logic w, input logic [31:0] a,
                        input logic [7:0] d, input bit ign, input bit fwd,
                        input logic [31:0] ca, input logic ce, input logic exp_viol,
                        input string tag);
    int c0, d0;
    c0 = core_cnt; d0 = done_cnt;
    if (!ign) begin
      if (fwd) core_q.push_back('{a: ca, w: w, e: ce, d: d, tag: tag});
      host_q.push_back('{rd: !w, rdata: fwd ? resp_data(ca) : 8'hFF, viol: exp_viol, tag: tag});
    end
    @(negedge clk);
    cur_kind = kind; req_kind = kind; req_write = w; req_addr = a; req_wdata = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (ign) begin
      for (int i = 0; i < 6; i++) begin
        check(sync == 2'b00, {tag, " R4 sync idle"}, sync, 0);
        @(negedge clk);
      end
      check(core_cnt == c0 && done_cnt == d0, {tag, " R4 ignored"}, core_cnt + done_cnt, c0 + d0);
    end else begin
      if (!fwd) check(done == 1'b1, {tag, " R8 done next cycle"}, done, 1);
      for (int i = 0; i < 60 && done_cnt == d0; i++) @(negedge clk);
      check(done_cnt == d0 + 1, {tag, " completion"}, done_cnt, d0 + 1);
      check(core_cnt == c0 + (fwd ? 1 : 0), {tag, " core count"}, core_cnt, c0 + (fwd ? 1 : 0));
      @(negedge clk);
    end
  endtask

  initial begin
    #40000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(cvalid == 0, "R1 core_valid", cvalid, 0);
    check(done == 0, "R1 done", done, 0);
    check(viol == 0, "R1 viol", viol, 0);
    check(sync == 2'b00, "R1 sync", sync, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cvalid == 0 && sync == 2'b00, "R1 after release", {cvalid, sync}, 0);

    legacy_en = 1; lock = 1;
    // R2 alias range, memory read
    access(2'b00, 0, 32'h000F_1234, 0, 0, 1, 32'hFFFF_1234, 0, 0, "R2 alias read");
    // R2 top range, firmware-hub read, slow core
    resp_delay = 3;
    access(2'b01, 0, 32'hFFFE_00AB, 0, 0, 1, 32'hFFFE_00AB, 0, 0, "R2 fwh read R9");
    resp_delay = 1;
    // R11 erase on base write
    erase_en = 1; flash_en = 1;
    access(2'b00, 1, 32'h000E_0010, 8'hC3, 0, 1, 32'hFFFE_0010, 1, 0, "R11 erase write");
    flash_en = 0;
    access(2'b00, 1, 32'h000E_0011, 8'h3C, 0, 1, 32'hFFFE_0011, 0, 0, "R11 flash off");
    flash_en = 1;
    // R3 user window n=12
    legacy_en = 0; user_en = 1; user_base = 32'hD000_0000; win_exp = 5'd12;
    access(2'b00, 0, 32'hD000_0ABC, 0, 0, 1, 32'hFFFF_FABC, 0, 0, "R3 n12 read");
    // R3 n=24 write lands in expansion, no erase (R11)
    win_exp = 5'd24;
    access(2'b01, 1, 32'hD012_3456, 8'h77, 0, 1, 32'hFF12_3456, 0, 0, "R3 n24 write");
    // R4 window outside 12..24
    win_exp = 5'd11;
    access(2'b00, 0, 32'hD000_0ABC, 0, 1, 0, 0, 0, 0, "R4 n11");
    win_exp = 5'd25;
    access(2'b00, 0, 32'hD000_0ABC, 0, 1, 0, 0, 0, 0, "R4 n25");
    // R4 miss and disabled legacy
    win_exp = 5'd12;
    access(2'b00, 0, 32'hC000_0000, 0, 1, 0, 0, 0, 0, "R4 miss");
    access(2'b00, 0, 32'h000F_1234, 0, 1, 0, 0, 0, 0, "R4 legacy off");
    // R3 priority
    user_base = 32'h000E_0000; win_exp = 5'd16;
    access(2'b00, 0, 32'h000E_1234, 0, 0, 1, 32'hFFFF_1234, 0, 0, "R3 user only");
    legacy_en = 1;
    access(2'b00, 0, 32'h000E_1234, 0, 0, 1, 32'hFFFE_1234, 0, 0, "R3 legacy priority");
    // R5 indirect, unchanged address, no LWAIT
    resp_delay = 2;
    access(2'b10, 0, 32'hFF00_0020, 0, 0, 1, 32'hFF00_0020, 0, 0, "R5 indirect read");
    check(viol == 0, "R8 no viol yet", viol, 0);
    // R6 out of range -> reject
    access(2'b10, 0, 32'h0000_1000, 0, 0, 0, 0, 0, 1, "R6 R8 range reject");
    // R8 sticky after accepted access
    access(2'b10, 0, 32'hFF00_0021, 0, 0, 1, 32'hFF00_0021, 0, 1, "R8 sticky");
    // R7 write without lock
    lock = 0;
    access(2'b00, 1, 32'hFFFF_0000, 8'h11, 0, 0, 0, 0, 1, "R7 no lock");
    lock = 1;
    // R6 protections
    brp = 1;
    access(2'b00, 0, 32'hFFFF_0001, 0, 0, 0, 0, 0, 1, "R6 base rd prot");
    access(2'b00, 1, 32'hFFFF_0002, 8'h22, 0, 1, 32'hFFFF_0002, 1, 1, "R6 base write ok");
    brp = 0; ewp = 1;
    access(2'b10, 1, 32'hFF00_0030, 8'h33, 0, 0, 0, 0, 1, "R6 exp wr prot");
    access(2'b10, 0, 32'hFF00_0030, 0, 0, 1, 32'hFF00_0030, 0, 1, "R6 exp read ok");
    ewp = 0;

    repeat (4) @(negedge clk);
    check(core_q.size() == 0 && host_q.size() == 0, "R9 queues drained",
          core_q.size() + host_q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule